// File: doc/BRIEF.md
# MDIO Management Frame Receiver

This block is the PHY-side end of a two-wire serial management link. It is clocked by the management clock (MDC) and samples MDIO on each rising edge. It picks out read and write frames addressed to its own fixed PHY address. For a write it presents the register address, the 16-bit data and a one-cycle strobe. For a read it raises a one-cycle request, takes the returned word, and shifts it back out on a tri-state driver, most significant bit first. The registers themselves live outside the block.

A small control bit sets whether frames must be preceded by a run of consecutive one bits (the preamble, `PRE_LEN` bits long and 32 by default). The bit is written through a management write to a chosen register address and data bit. When it is 0, which is its reset value, frames are accepted with or without a preamble. A status output always shows the inverse of the effective enforcement. A compatibility input forces enforcement off and locks the control bit against writes.

The frame engine has eight named states:
- `ST_HUNT` waits for a start zero. A zero moves it to `ST_START` only if no preamble is required, or if the ones counter is saturated.
- `ST_START` goes to `ST_OPCODE` on a one and back to `ST_HUNT` on a zero.
- `ST_OPCODE` goes to `ST_PHYAD` after a read or write code. Any other code sends it back to `ST_HUNT`.
- `ST_PHYAD` goes to `ST_REGAD` on an address match and back to `ST_HUNT` on a mismatch.
- `ST_REGAD` always goes to `ST_TURN`.
- `ST_TURN` goes to `ST_RDATA` for a read or `ST_WDATA` for a write.
- `ST_WDATA` and `ST_RDATA` each return to `ST_HUNT` after the sixteenth data bit.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset, `mdio_oe` is 0, `wr_stb_o` and `rd_req_o` are 0, and `pre_optional_o` is 1, because enforcement resets to 0.
- R2: A frame is: start bits 0 then 1, a 2-bit opcode (10 = read, 01 = write), a 5-bit PHY address, a 5-bit register address, 2 turnaround bits and 16 data bits. Every field is sent MSB first.
- R3: For an accepted write, `wr_stb_o` is high for exactly one cycle, the cycle after the edge that samples the last data bit. In that cycle `reg_addr_o` and `wr_data_o` hold the frame's address and data.
- R4: For an accepted read, `rd_req_o` is high for one cycle, the cycle after the edge that samples the last register-address bit, with `reg_addr_o` valid. `rd_data_i` is taken at the second rising edge after that.
- R5: On a read, MDIO is released for the first turnaround bit and driven 0 for the second. The 16 data bits follow MSB first, and the line is released in the bit time after the last data bit.
- R6: A frame whose PHY address differs from `PHY_ADDR` gives no strobe, no request and no drive.
- R7: With enforcement off, a frame sent with no preamble is accepted.
- R8: With enforcement on, a frame is accepted only after at least `PRE_LEN` consecutive ones. With `PRE_LEN` = 32, a run of 31 ones is rejected and a run of 32 is accepted.
- R9: The ones counter saturates at `PRE_LEN`. Any zero seen outside a frame clears it, so a preamble split by a zero does not qualify.
- R10: A write to register `CTRL_REG` (default 5'h11) loads enforcement from data bit `ENF_BIT` (default 3). `pre_optional_o` shows the inverse of the effective enforcement.
- R11: While `compat_i` is 1, enforcement is inactive: `pre_optional_o` is 1 and frames need no preamble. Writes to the control bit are ignored, and the bit keeps its old value once `compat_i` falls.
- R12: A frame with opcode 00 or 11 gives no strobe and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| compat_i | input | 1 | Compatibility mode: forces enforcement off and locks the control bit |
| mdio_i | input | 1 | Sampled MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO while `mdio_oe` is 1 |
| mdio_oe | output | 1 | Tri-state enable for the MDIO driver |
| reg_addr_o | output | 5 | Register address of the last accepted frame |
| wr_data_o | output | 16 | Write data of the last accepted write |
| wr_stb_o | output | 1 | One-cycle write strobe |
| rd_req_o | output | 1 | One-cycle read request |
| rd_data_i | input | 16 | Read data returned by the register file |
| pre_optional_o | output | 1 | 1 when frames need no preamble (inverse of effective enforcement) |

## Verification
The bench builds the block with `PHY_ADDR` = 5'h0B and keeps `PRE_LEN` = 32, `CTRL_REG` = 5'h11 and `ENF_BIT` = 3.

The address 01011 lets the bench send a mismatching address 01010 that differs only in the final address bit. This reaches the latest possible exit from `ST_PHYAD`. Keeping the full 32-bit preamble puts the 31-versus-32 boundary and a 20+20 split preamble within reach.

The read-data word depends on the register address. An error in the capture edge or in the shift-out order therefore shows up as wrong bits on the line.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    // Frame engine states, one per frame field plus the hunt state.
    typedef enum logic [2:0] {
        ST_HUNT   = 3'd0,
        ST_START  = 3'd1,
        ST_OPCODE = 3'd2,
        ST_PHYAD  = 3'd3,
        ST_REGAD  = 3'd4,
        ST_TURN   = 3'd5,
        ST_WDATA  = 3'd6,
        ST_RDATA  = 3'd7
    } mdio_state_e;

    // Opcode encodings, first bit on the wire in bit 1.
    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    // Length of the two-bit fields (opcode and turnaround).
    localparam int unsigned PAIR_LEN = 2;

endpackage

// File: rtl/mdio_pre_tracker.sv
module mdio_pre_tracker #(
    parameter int unsigned PRE_LEN = 32
) (
    input  logic mdc,
    input  logic rst_n,
    input  logic mdio_i,
    input  logic in_frame,
    output logic pre_full
);
    localparam int unsigned CW = $clog2(PRE_LEN + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(PRE_LEN);

    logic [CW-1:0] ones_q;

    // Counts consecutive ones between frames; saturates; a zero clears it.
    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (!in_frame) begin
            if (!mdio_i) begin
                ones_q <= '0;
            end else if (ones_q != CNT_MAX) begin
                ones_q <= ones_q + CW'(1);
            end
        end
    end

    assign pre_full = (ones_q == CNT_MAX);

    // R9: counter never passes its limit
    a_r9_saturates: assert property (@(posedge mdc) disable iff (!rst_n)
        ones_q <= CNT_MAX);

    // R9: a zero outside a frame removes any qualification
    a_r9_zero_clears: assert property (@(posedge mdc) disable iff (!rst_n)
        (!in_frame && !mdio_i) |=> !pre_full);

endmodule

// File: rtl/mdio_enf_ctl.sv
module mdio_enf_ctl #(
    parameter int unsigned ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] CTRL_REG = 5'h11
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              compat_i,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    output logic              enf_eff,
    output logic              pre_optional_o
);
    logic enf_q;
    logic hit;

    assign hit = wr_stb && (wr_addr == CTRL_REG);

    // Enforcement bit: resets clear, locked while compatibility mode is on.
    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            enf_q <= 1'b0;
        end else if (hit && !compat_i) begin
            enf_q <= wr_bit;
        end
    end

    assign enf_eff        = enf_q && !compat_i;
    assign pre_optional_o = !enf_eff;

    // R11: compatibility mode freezes the stored bit
    a_r11_compat_holds: assert property (@(posedge mdc) disable iff (!rst_n)
        compat_i |=> $stable(enf_q));

    // R10: the stored bit moves only on a control-register write
    a_r10_only_by_write: assert property (@(posedge mdc) disable iff (!rst_n)
        !hit |=> $stable(enf_q));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 16,
    parameter logic [ADDR_W-1:0] PHY_ADDR = '0
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic              start_ok,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              in_frame,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_stb_o,
    output logic              rd_req_o,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int unsigned CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_AD   = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_DT   = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_PAIR = CNT_W'(PAIR_LEN - 1);

    mdio_state_e       st_q, st_d;
    logic [CNT_W-1:0]  bcnt_q, bcnt_d;
    logic [DATA_W-2:0] sh_q;
    logic [DATA_W-1:0] sh_next;
    logic [DATA_W-2:0] rd_sh_q;
    logic              is_rd_q;
    logic              ad_last, dt_last, pair_last, op_valid, phy_hit;

    assign sh_next   = {sh_q, mdio_i};
    assign ad_last   = (bcnt_q == LAST_AD);
    assign dt_last   = (bcnt_q == LAST_DT);
    assign pair_last = (bcnt_q == LAST_PAIR);
    assign op_valid  = (sh_next[1:0] == OP_RD) || (sh_next[1:0] == OP_WR);
    assign phy_hit   = (sh_next[ADDR_W-1:0] == PHY_ADDR);
    assign in_frame  = (st_q != ST_HUNT);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HUNT:   if (!mdio_i && start_ok) st_d = ST_START;
            ST_START:  st_d = mdio_i ? ST_OPCODE : ST_HUNT;
            ST_OPCODE: if (pair_last) st_d = op_valid ? ST_PHYAD : ST_HUNT;
            ST_PHYAD:  if (ad_last) st_d = phy_hit ? ST_REGAD : ST_HUNT;
            ST_REGAD:  if (ad_last) st_d = ST_TURN;
            ST_TURN:   if (pair_last) st_d = is_rd_q ? ST_RDATA : ST_WDATA;
            ST_WDATA:  if (dt_last) st_d = ST_HUNT;
            ST_RDATA:  if (dt_last) st_d = ST_HUNT;
            default:   st_d = ST_HUNT;
        endcase
    end

    // Bit counter restarts at every field boundary
    always_comb begin
        if ((st_d != st_q) || (st_q == ST_HUNT)) begin
            bcnt_d = '0;
        end else begin
            bcnt_d = bcnt_q + CNT_W'(1);
        end
    end

    // State register process
    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_HUNT;
            bcnt_q  <= '0;
            sh_q    <= '0;
            is_rd_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            bcnt_q <= bcnt_d;
            sh_q   <= sh_next[DATA_W-2:0];
            if (st_q == ST_OPCODE && pair_last) begin
                is_rd_q <= (sh_next[1:0] == OP_RD);
            end
        end
    end

    // Output process: strobes, captured fields and the MDIO driver
    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            reg_addr_o <= '0;
            wr_data_o  <= '0;
            wr_stb_o   <= 1'b0;
            rd_req_o   <= 1'b0;
            mdio_o     <= 1'b1;
            mdio_oe    <= 1'b0;
            rd_sh_q    <= '0;
        end else begin
            wr_stb_o <= 1'b0;
            rd_req_o <= 1'b0;
            unique case (st_q)
                ST_REGAD: begin
                    if (ad_last) begin
                        reg_addr_o <= sh_next[ADDR_W-1:0];
                        rd_req_o   <= is_rd_q;
                    end
                end
                ST_TURN: begin
                    if (is_rd_q && !pair_last) begin
                        mdio_oe <= 1'b1;
                        mdio_o  <= 1'b0;
                    end else if (is_rd_q) begin
                        rd_sh_q <= rd_data_i[DATA_W-2:0];
                        mdio_o  <= rd_data_i[DATA_W-1];
                    end
                end
                ST_WDATA: begin
                    if (dt_last) begin
                        wr_data_o <= sh_next;
                        wr_stb_o  <= 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (dt_last) begin
                        mdio_oe <= 1'b0;
                        mdio_o  <= 1'b1;
                    end else begin
                        mdio_o  <= rd_sh_q[DATA_W-2];
                        rd_sh_q <= {rd_sh_q[DATA_W-3:0], 1'b0};
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // R5: first turnaround bit is released while the request is out
    a_r5_ta_release: assert property (@(posedge mdc) disable iff (!rst_n)
        rd_req_o |-> !mdio_oe);

    // R5: second turnaround bit is driven low
    a_r5_ta_zero: assert property (@(posedge mdc) disable iff (!rst_n)
        rd_req_o |=> (mdio_oe && !mdio_o));

    // R3: write strobe lasts one cycle
    a_r3_wr_pulse: assert property (@(posedge mdc) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R6: the line is driven only in the read tail of a frame
    a_r6_drive_in_read: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |-> (st_q == ST_TURN || st_q == ST_RDATA));

    // R2: a frame is either a read or a write, never both
    a_r2_one_kind: assert property (@(posedge mdc) disable iff (!rst_n)
        !(wr_stb_o && rd_req_o));

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned PRE_LEN  = 32,
    parameter logic [ADDR_W-1:0] PHY_ADDR = 5'h01,
    parameter logic [ADDR_W-1:0] CTRL_REG = 5'h11,
    parameter int unsigned ENF_BIT  = 3
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              compat_i,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_stb_o,
    output logic              rd_req_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              pre_optional_o
);
    logic in_frame;
    logic pre_full;
    logic enf_eff;
    logic start_ok;

    assign start_ok = !enf_eff || pre_full;

    mdio_pre_tracker #(
        .PRE_LEN (PRE_LEN)
    ) u_pre (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .mdio_i   (mdio_i),
        .in_frame (in_frame),
        .pre_full (pre_full)
    );

    mdio_enf_ctl #(
        .ADDR_W   (ADDR_W),
        .CTRL_REG (CTRL_REG)
    ) u_enf (
        .mdc            (mdc),
        .rst_n          (rst_n),
        .compat_i       (compat_i),
        .wr_stb         (wr_stb_o),
        .wr_addr        (reg_addr_o),
        .wr_bit         (wr_data_o[ENF_BIT]),
        .enf_eff        (enf_eff),
        .pre_optional_o (pre_optional_o)
    );

    mdio_frame_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PHY_ADDR (PHY_ADDR)
    ) u_fsm (
        .mdc        (mdc),
        .rst_n      (rst_n),
        .mdio_i     (mdio_i),
        .start_ok   (start_ok),
        .rd_data_i  (rd_data_i),
        .in_frame   (in_frame),
        .reg_addr_o (reg_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_stb_o   (wr_stb_o),
        .rd_req_o   (rd_req_o),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    // R8: with enforcement on, a frame is entered only from a full preamble
    a_r8_needs_preamble: assert property (@(posedge mdc) disable iff (!rst_n)
        (!in_frame && enf_eff && !pre_full) |=> !in_frame);

endmodule

// File: tb/mdio_mgmt_slave_test.sv
module mdio_mgmt_slave_test;

    localparam logic [4:0] PHY  = 5'h0B;
    localparam logic [4:0] BAD  = 5'h0A;
    localparam logic [4:0] CTRL = 5'h11;

    typedef struct {
        bit          rd;
        logic [4:0]  a;
        logic [15:0] d;
        string       tag;
    } exp_t;

    logic        mdc = 1'b0;
    logic        rst_n;
    logic        compat_i;
    logic        mdio_i;
    logic        mdio_o, mdio_oe;
    logic [4:0]  reg_addr_o;
    logic [15:0] wr_data_o;
    logic        wr_stb_o, rd_req_o;
    logic [15:0] rd_data_i;
    logic        pre_optional_o;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;
    exp_t sb[$];
    exp_t mon_e;

    always #4 mdc = ~mdc;

    function automatic logic [15:0] rd_model(input logic [4:0] a);
        return {~a, a[2:0], 8'hC3};
    endfunction

    assign rd_data_i = rd_model(reg_addr_o);

    mdio_mgmt_slave #(
        .PHY_ADDR (PHY),
        .CTRL_REG (CTRL),
        .ENF_BIT  (3)
    ) uut (
        .mdc            (mdc),
        .rst_n          (rst_n),
        .compat_i       (compat_i),
        .mdio_i         (mdio_i),
        .mdio_o         (mdio_o),
        .mdio_oe        (mdio_oe),
        .reg_addr_o     (reg_addr_o),
        .wr_data_o      (wr_data_o),
        .wr_stb_o       (wr_stb_o),
        .rd_req_o       (rd_req_o),
        .rd_data_i      (rd_data_i),
        .pre_optional_o (pre_optional_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge mdc);
        mdio_i = b;
    endtask

    // Driver: pushes the expected item, then clocks the frame out
    task automatic run_frame(input int pre_n, input bit split, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] wd, input bit accept, input string tag);
        bit is_rd = (op == 2'b10);
        logic [15:0] rexp = rd_model(ra);
        exp_t e;
        if (accept) begin
            e.rd = is_rd; e.a = ra; e.d = wd; e.tag = tag;
            sb.push_back(e);
        end
        send_bit(1'b0);
        send_bit(1'b0);
        for (int i = 0; i < pre_n; i++) begin
            if (split && i == pre_n / 2) send_bit(1'b0);
            send_bit(1'b1);
        end
        send_bit(1'b0);
        send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 4; i >= 0; i--) send_bit(phy[i]);
        for (int i = 4; i >= 0; i--) send_bit(ra[i]);
        if (is_rd && accept) begin
            send_bit(1'b1);
            chk(!mdio_oe, "R5", "first turnaround released", {31'd0, mdio_oe}, 32'd0);
            send_bit(1'b1);
            chk(mdio_oe && !mdio_o, "R5", "second turnaround low",
                {30'd0, mdio_oe, mdio_o}, 32'd2);
            for (int j = 15; j >= 0; j--) begin
                send_bit(1'b1);
                chk(mdio_oe && (mdio_o == rexp[j]), "R4", "read data bit",
                    {15'd0, j[15:0], mdio_oe, mdio_o}, {15'd0, j[15:0], 1'b1, rexp[j]});
            end
            send_bit(1'b1);
            chk(!mdio_oe, "R5", "release after last bit", {31'd0, mdio_oe}, 32'd0);
        end else begin
            send_bit(is_rd ? 1'b1 : 1'b1);
            send_bit(is_rd ? 1'b1 : 1'b0);
            if (is_rd) chk(!mdio_oe, "R6", "no drive on rejected read",
                           {31'd0, mdio_oe}, 32'd0);
            for (int j = 15; j >= 0; j--) send_bit(is_rd ? 1'b1 : wd[j]);
            send_bit(1'b1);
        end
        send_bit(1'b1);
    endtask

    // Monitor: pops expected items as strobes and requests appear
    always @(negedge mdc) begin
        if (rst_n === 1'b1) begin
            if (wr_stb_o) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R6", "unexpected write strobe", {11'd0, reg_addr_o, wr_data_o}, 32'd0);
                end else begin
                    mon_e = sb.pop_front();
                    chk(!mon_e.rd && reg_addr_o == mon_e.a && wr_data_o == mon_e.d, mon_e.tag,
                        "write addr/data", {11'd0, reg_addr_o, wr_data_o},
                        {10'd0, mon_e.rd, mon_e.a, mon_e.d});
                end
            end
            if (rd_req_o) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R6", "unexpected read request", {27'd0, reg_addr_o}, 32'd0);
                end else begin
                    mon_e = sb.pop_front();
                    chk(mon_e.rd && reg_addr_o == mon_e.a, mon_e.tag, "read request addr",
                        {26'd0, 1'b1, reg_addr_o}, {26'd0, mon_e.rd, mon_e.a});
                end
            end
        end
    end

    initial begin
        rst_n = 1'b0; mdio_i = 1'b1; compat_i = 1'b0;
        repeat (4) @(negedge mdc);
        rst_n = 1'b1;
        @(negedge mdc);
        // R1 reset state
        chk(!mdio_oe, "R1", "oe after reset", {31'd0, mdio_oe}, 32'd0);
        chk(!wr_stb_o && !rd_req_o, "R1", "strobes after reset",
            {30'd0, wr_stb_o, rd_req_o}, 32'd0);
        chk(pre_optional_o, "R1", "preamble optional after reset",
            {31'd0, pre_optional_o}, 32'd1);

        // R7 / R3 / R4 / R2: enforcement off, with and without preamble
        run_frame(0,  0, 2'b01, PHY, 5'h03, 16'hA5C3, 1, "R7");
        run_frame(0,  0, 2'b10, PHY, 5'h07, 16'h0000, 1, "R4");
        run_frame(32, 0, 2'b01, PHY, 5'h1E, 16'h8001, 1, "R3");
        run_frame(5,  0, 2'b10, PHY, 5'h18, 16'h0000, 1, "R2");

        // R10: turn enforcement on through the control register
        run_frame(0, 0, 2'b01, PHY, CTRL, 16'h0008, 1, "R10");
        chk(!pre_optional_o, "R10", "status after enabling",
            {31'd0, pre_optional_o}, 32'd0);

        // R8: preamble length boundary
        run_frame(31, 0, 2'b01, PHY, 5'h02, 16'h1234, 0, "R8");
        run_frame(32, 0, 2'b01, PHY, 5'h02, 16'h4321, 1, "R8");
        run_frame(0,  0, 2'b01, PHY, 5'h05, 16'hFFFF, 0, "R8");
        run_frame(40, 0, 2'b10, PHY, 5'h0C, 16'h0000, 1, "R8");

        // R9: split preamble never qualifies
        run_frame(40, 1, 2'b01, PHY, 5'h06, 16'h7777, 0, "R9");

        // R6: address mismatch in last address bit
        run_frame(32, 0, 2'b01, BAD, 5'h04, 16'h0F0F, 0, "R6");
        run_frame(32, 0, 2'b10, BAD, 5'h04, 16'h0000, 0, "R6");

        // R12: invalid opcodes
        run_frame(32, 0, 2'b11, PHY, 5'h09, 16'hAAAA, 0, "R12");
        run_frame(32, 0, 2'b00, PHY, 5'h09, 16'h5555, 0, "R12");

        // R11: compatibility mode
        compat_i = 1'b1;
        @(negedge mdc);
        chk(pre_optional_o, "R11", "status forced in compat",
            {31'd0, pre_optional_o}, 32'd1);
        run_frame(0, 0, 2'b01, PHY, CTRL, 16'h0000, 1, "R11");
        run_frame(0, 0, 2'b10, PHY, 5'h0D, 16'h0000, 1, "R11");
        compat_i = 1'b0;
        @(negedge mdc);
        chk(!pre_optional_o, "R11", "bit kept after compat",
            {31'd0, pre_optional_o}, 32'd0);
        run_frame(0, 0, 2'b01, PHY, 5'h01, 16'h2222, 0, "R11");

        // R10: clear enforcement again
        run_frame(32, 0, 2'b01, PHY, CTRL, 16'hFFF7, 1, "R10");
        chk(pre_optional_o, "R10", "status after clearing",
            {31'd0, pre_optional_o}, 32'd1);
        run_frame(0, 0, 2'b10, PHY, 5'h1F, 16'h0000, 1, "R7");

        chk(sb.size() == 0, "R3", "all expected items seen", sb.size(), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge mdc);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R2 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule